// File: doc/BRIEF.md
# Multi-Rail Reset Sequencer

This block turns the digital undervoltage flags of several supply rails into one status line per rail and a single active-low system reset. External comparators decide whether each rail is below its threshold; this logic only decides what the outputs do about it. The per-rail lines follow their flags with no delay. The system reset is a stretched OR of every reset cause: a low rail, the manual reset, an undervoltage lockout of the supervisor's own supply, and a watchdog expiry pulse. Once the last cause goes away, the reset is held for a programmable number of clock cycles. A cause that comes back while that count is running starts the count again.

A margin override lets supplies be moved from nominal during system test. While it is active, every output is forced to its released (high) state. A watchdog expiry that arrives during margin is held back. It is replayed a fixed number of cycles after margin ends. Lockout has priority over everything else and drives every output low. The manual reset and margin inputs are asynchronous and pass through two-flop synchronizers. The rail flags, the lockout flag and the watchdog pulse are taken as already synchronous to the clock.

The timeout length is applied on `timeout_cycles_i`. At 250 MHz, a value of 35,000,000 gives the usual 140 ms minimum.

Top module: `rail_supervisor`

## Requirements
- R1: `rail_good_o[i]` is 0 in the same cycle that `rail_low_i[i]` is 1 (rail below threshold). It is 1 in the same cycle that the flag is 0. This holds when lockout and margin are inactive and the logic is out of reset.
- R2: `sys_rst_n_o` goes low one clock edge after any `rail_low_i` bit is 1. It also goes low when `mr_n_i` is low, which is seen three edges later because of the synchronizer.
- R3: After the first clock edge at which every cause is clear, `sys_rst_n_o` rises on exactly the T-th edge, counting that edge as the first, where T = `timeout_cycles_i`. A value of 0 acts as 1. A manual reset release therefore takes T+2 edges.
- R4: If any cause reappears while the timeout count is running, the count restarts. The reset then rises T edges after the cause clears again.
- R5: While the synchronized margin input is low, `sys_rst_n_o` and every `rail_good_o` bit are 1, whatever the rail flags are.
- R6: While `uvlo_i` is 1, `sys_rst_n_o` and every `rail_good_o` bit are 0 in the same cycle. After `uvlo_i` clears, the reset rises T edges later.
- R7: A one-cycle `wdog_expired_i` pulse outside margin pulls `sys_rst_n_o` low on the next edge. The reset then rises T edges after the pulse.
- R8: A watchdog pulse during margin does not assert the reset. It is remembered instead. `sys_rst_n_o` goes low on edge MARGIN_DLY+3 after `margin_n_i` is released, counting the first edge after release as 1.
- R9: While `rst_n` is low, every output is 0. After release, with no cause present, `sys_rst_n_o` rises on the T-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the logic |
| rail_low_i | input | N_RAILS | 1 = rail i is below its threshold |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| margin_n_i | input | 1 | Margin override, active low, asynchronous |
| uvlo_i | input | 1 | 1 = supervisor supply is in lockout |
| wdog_expired_i | input | 1 | One-cycle pulse when the watchdog expires |
| timeout_cycles_i | input | CNT_W | Reset hold time in clock cycles |
| rail_good_o | output | N_RAILS | Per-rail status, 0 = rail low |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
The assertions assume the following about the inputs:
- `wdog_expired_i` is a single-cycle pulse.
- `rail_low_i`, `uvlo_i` and `timeout_cycles_i` are already synchronous to the clock.
- `timeout_cycles_i` stays constant while a timeout is being counted.

The stimulus respects these assumptions:
- Every input changes only on the falling clock edge.
- Each watchdog pulse is removed on the next falling edge.
- The timeout value is changed only while the reset is idle and high.
- The bench waits for the margin synchronizer to settle before it pulses the watchdog inside a margin window.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // A zero timeout is treated as a single cycle.
  function automatic logic [31:0] eff_limit(input logic [31:0] t);
    return (t == 32'd0) ? 32'd1 : t;
  endfunction
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/sup_wdog_defer.sv
module sup_wdog_defer #(
  parameter int DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic margin_act_i,
  input  logic wdog_i,
  output logic cause_o
);
  localparam int DW = $clog2(DLY + 1);
  logic          pend_q;
  logic [DW-1:0] cnt_q;
  logic          fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (wdog_i && margin_act_i) begin
        pend_q <= 1'b1;
        cnt_q  <= '0;
      end else if (pend_q && !margin_act_i) begin
        if (cnt_q >= DW'(DLY - 1)) begin
          pend_q <= 1'b0;
          fire_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // Outside margin a pulse acts at once; inside it is replayed later.
  assign cause_o = (wdog_i && !margin_act_i) || fire_q;

  p_pending_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && margin_act_i) |=> pend_q);
  p_fire_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
endmodule

// File: rtl/sup_reset_timer.sv
module sup_reset_timer #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cause_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             rst_q_o
);
  import sup_pkg::*;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [31:0]      lim32;

  always_comb begin
    lim32 = eff_limit(32'(limit_i));
    lim   = lim32[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q_o <= 1'b1;
      cnt_q   <= '0;
    end else if (cause_i) begin
      rst_q_o <= 1'b1;
      cnt_q   <= '0;
    end else if (rst_q_o) begin
      if (cnt_q >= lim - 1'b1) begin
        rst_q_o <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cause_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cause_i |=> rst_q_o);
  p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim);
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_i && rst_q_o) |=> (cnt_q == '0));
  p_release_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q_o) |-> !$past(cause_i));
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
  parameter int N_RAILS    = 4,
  parameter int CNT_W      = 26,
  parameter int MARGIN_DLY = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_low_i,
  input  logic               mr_n_i,
  input  logic               margin_n_i,
  input  logic               uvlo_i,
  input  logic               wdog_expired_i,
  input  logic [CNT_W-1:0]   timeout_cycles_i,
  output logic [N_RAILS-1:0] rail_good_o,
  output logic               sys_rst_n_o
);
  logic mr_n_s, margin_n_s, margin_act;
  logic wd_cause, cause, rst_q, run_q;

  sup_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst_n(rst_n), .d_i(mr_n_i), .q_o(mr_n_s));
  sup_sync2 #(.RST_VAL(1'b1)) u_margin_sync (
    .clk(clk), .rst_n(rst_n), .d_i(margin_n_i), .q_o(margin_n_s));

  assign margin_act = !margin_n_s;

  sup_wdog_defer #(.DLY(MARGIN_DLY)) u_defer (
    .clk(clk), .rst_n(rst_n), .margin_act_i(margin_act),
    .wdog_i(wdog_expired_i), .cause_o(wd_cause));

  assign cause = (|rail_low_i) || !mr_n_s || uvlo_i || wd_cause;

  sup_reset_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cause_i(cause),
    .limit_i(timeout_cycles_i), .rst_q_o(rst_q));

  // Holds all outputs asserted until the first edge after logic reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    always_comb begin
      if (uvlo_i || !run_q) rail_good_o[g] = 1'b0;
      else if (margin_act)  rail_good_o[g] = 1'b1;
      else                  rail_good_o[g] = !rail_low_i[g];
    end
  end

  always_comb begin
    if (uvlo_i || !run_q) sys_rst_n_o = 1'b0;
    else if (margin_act)  sys_rst_n_o = 1'b1;
    else                  sys_rst_n_o = !rst_q;
  end

  p_uvlo_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> (!sys_rst_n_o && (rail_good_o == '0)));
  p_margin_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (margin_act && !uvlo_i && run_q) |-> (sys_rst_n_o && (&rail_good_o)));
  p_rail_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rail_low_i) && !uvlo_i) |=> (!sys_rst_n_o || margin_act));
endmodule

// File: tb/rail_supervisor_tb_top.sv
module rail_supervisor_tb_top;
  localparam int N  = 4;
  localparam int CW = 26;
  localparam int D  = 6;
  localparam int T  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rail_low = '0;
  logic mr_n = 1'b1, margin_n = 1'b1, uvlo = 1'b0, wd = 1'b0;
  logic [CW-1:0] tmo = CW'(T);
  logic [N-1:0] rail_good;
  logic sys_rst_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rail_supervisor #(.N_RAILS(N), .CNT_W(CW), .MARGIN_DLY(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .rail_low_i(rail_low), .mr_n_i(mr_n),
    .margin_n_i(margin_n), .uvlo_i(uvlo), .wdog_expired_i(wd),
    .timeout_cycles_i(tmo), .rail_good_o(rail_good), .sys_rst_n_o(sys_rst_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts edges, with a check after each one, until sys_rst_n reaches lvl.
  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (sys_rst_n !== lvl && n < 2000);
  endtask

  task automatic settle();
    int n;
    @(negedge clk);
    rail_low = '0; mr_n = 1'b1; margin_n = 1'b1; uvlo = 1'b0; wd = 1'b0;
    edges_until(1'b1, n);
    @(negedge clk);
  endtask

  task automatic t_power_on();
    int n;
    #1;
    chk(sys_rst_n == 1'b0, "R9 reset low in logic reset", sys_rst_n, 0);
    chk(rail_good == '0, "R9 rails low in logic reset", rail_good, 0);
    @(negedge clk); rst_n = 1'b1;
    edges_until(1'b1, n);
    chk(n == T, "R9 edges to first release", n, T);
    chk(rail_good == '1, "R9 rails good after release", rail_good, 15);
  endtask

  task automatic t_rail_follow();
    int n;
    rail_low = 4'b0100; #1;
    chk(rail_good == 4'b1011, "R1 rail 2 low same cycle", rail_good, 11);
    @(posedge clk); #1;
    chk(sys_rst_n == 1'b0, "R2 reset after low rail", sys_rst_n, 0);
    @(negedge clk); rail_low = 4'b1001; #1;
    chk(rail_good == 4'b0110, "R1 rails 0 and 3 low", rail_good, 6);
    @(negedge clk); rail_low = '0; #1;
    chk(rail_good == 4'b1111, "R1 rails restored", rail_good, 15);
    edges_until(1'b1, n);
    chk(n == T, "R3 hold after rails clear", n, T);
  endtask

  task automatic t_manual();
    int n;
    mr_n = 1'b0;
    edges_until(1'b0, n);
    chk(n == 3, "R2 manual reset latency", n, 3);
    @(negedge clk); mr_n = 1'b1;
    edges_until(1'b1, n);
    chk(n == T + 2, "R3 hold after manual release", n, T + 2);
  endtask

  task automatic t_restart();
    int n;
    rail_low = 4'b0001;
    repeat (2) @(negedge clk);
    rail_low = '0;
    repeat (4) @(negedge clk);
    #1; chk(sys_rst_n == 1'b0, "R4 still held mid-count", sys_rst_n, 0);
    rail_low = 4'b0010;
    @(negedge clk); rail_low = '0;
    edges_until(1'b1, n);
    chk(n == T, "R4 count restarted", n, T);
  endtask

  task automatic t_zero_timeout();
    int n;
    tmo = '0;
    rail_low = 4'b1000;
    @(negedge clk); rail_low = '0;
    edges_until(1'b1, n);
    chk(n == 1, "R3 zero timeout acts as one", n, 1);
    @(negedge clk); tmo = CW'(T);
  endtask

  task automatic t_margin();
    margin_n = 1'b0;
    repeat (3) @(negedge clk);
    rail_low = 4'b0110; mr_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(rail_good == 4'b1111, "R5 rails forced high", rail_good, 15);
    chk(sys_rst_n == 1'b1, "R5 reset forced high", sys_rst_n, 1);
    rail_low = 4'b1111;
    @(negedge clk); #1;
    chk(rail_good == 4'b1111, "R5 rails unchanged in margin", rail_good, 15);
    margin_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(rail_good == 4'b0000, "R5 rails follow after margin", rail_good, 0);
    chk(sys_rst_n == 1'b0, "R5 reset shown after margin", sys_rst_n, 0);
    settle();
  endtask

  task automatic t_uvlo();
    int n;
    uvlo = 1'b1; #1;
    chk(sys_rst_n == 1'b0, "R6 lockout reset low", sys_rst_n, 0);
    chk(rail_good == '0, "R6 lockout rails low", rail_good, 0);
    margin_n = 1'b0;
    repeat (4) @(negedge clk); #1;
    chk(sys_rst_n == 1'b0 && rail_good == '0, "R6 lockout beats margin", sys_rst_n, 0);
    margin_n = 1'b1;
    repeat (3) @(negedge clk);
    uvlo = 1'b0;
    edges_until(1'b1, n);
    chk(n == T, "R6 hold after lockout", n, T);
  endtask

  task automatic t_wdog();
    int n;
    wd = 1'b1;
    @(posedge clk); #1;
    chk(sys_rst_n == 1'b0, "R7 watchdog asserts reset", sys_rst_n, 0);
    @(negedge clk); wd = 1'b0;
    edges_until(1'b1, n);
    chk(n == T, "R7 hold after watchdog", n, T);
  endtask

  task automatic t_wdog_margin();
    int n;
    margin_n = 1'b0;
    repeat (4) @(negedge clk);
    wd = 1'b1;
    @(negedge clk); wd = 1'b0;
    repeat (3) @(negedge clk);
    #1; chk(sys_rst_n == 1'b1, "R8 no reset during margin", sys_rst_n, 1);
    @(negedge clk); margin_n = 1'b1;
    edges_until(1'b0, n);
    chk(n == D + 3, "R8 deferred watchdog delay", n, D + 3);
    edges_until(1'b1, n);
    chk(n == T, "R8 hold after deferred reset", n, T);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_power_on();     settle();
    t_rail_follow();  settle();
    t_manual();       settle();
    t_restart();      settle();
    t_zero_timeout(); settle();
    t_margin();       settle();
    t_uvlo();         settle();
    t_wdog();         settle();
    t_wdog_margin();  settle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule